// File: doc/BRIEF.md
# Dual Simultaneous ADC Serial Reader

This block is the host-side master for a serial converter that holds two successive-approximation ADCs. Both ADCs sample at the same instant. The block pulls chip select low to take a sample, and that same edge starts the conversion. It then generates the serial clock from the system clock and deserializes the two 12-bit results. The results arrive in one of two ways: both at once on two data lines, or one after the other on a single shared line. There is no pipeline delay, so the words handed back after a frame come from the sample taken at the start of that same frame.

While no frame is running, the block drives the converter's 3-bit channel address and its differential/single-ended mode pin. The address comes either from a fixed input or from a short programmable list that advances once per frame. The result words can be re-coded between straight binary and two's complement, so that downstream logic always sees one coding. Frames can be issued on request, one per start pulse. They can also repeat back-to-back with a programmable quiet gap. A sleep request stops the repetition and keeps chip select high until the next start.

Top module: `dual_adc_reader`

## Requirements
- R1: During and right after reset, chip select is high, the serial clock is high, the valid strobe is low and both result words are zero.
- R2: A frame drops chip select. It then issues 16 serial clock periods in two-line mode, or 32 in one-line mode. Each period is HALF_CYC system clocks low followed by HALF_CYC system clocks high. The first falling serial clock edge comes HALF_CYC cycles after chip select falls. Chip select rises HALF_CYC cycles after the last rising edge.
- R3: In two-line mode, serial bit k of a frame (k = 0 first) is sampled on the k-th rising edge. Result A is taken from line A and result B from line B, each as bits 2..13 with the MSB first. Bits 0, 1, 14 and 15 have no effect on the results.
- R4: In one-line mode, both results are read from line A. Result A is frame bits 2..13 and result B is frame bits 18..29, each MSB first. Line B and the remaining bits have no effect.
- R5: The valid strobe is high for exactly one cycle, in the first cycle in which chip select is high again. It carries the results of the frame that just ended.
- R6: If the converter-coding input (1 = two's complement) differs from the wanted-coding input, the result MSB is inverted, which equals adding 2048 modulo 4096. If the two inputs are equal, the result is passed through unchanged. Both inputs are latched when the frame starts.
- R7: With the sequencer off, the address pins follow the fixed address input while chip select is high. They hold steady while chip select is low. The result address tag equals the address driven during that frame.
- R8: With the sequencer on, frames use list entries 0, 1, …, last, then wrap to entry 0. Entry i sits at bits [3i+2:3i] of the list input. The index only advances on frames run with the sequencer on.
- R9: The mode pin follows the differential-mode input while chip select is high, and holds steady while chip select is low.
- R10: Between two frames, chip select stays high for at least quiet+1 cycles. When frames repeat back-to-back, the gap is exactly quiet+1 cycles.
- R11: With sleep low, one start causes frames to repeat continuously. With sleep high, no frame starts without a start pulse, and chip select stays high.
- R12: A start pulse that arrives during a frame is remembered and launches exactly one further frame after the quiet gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame |
| sleep_i | input | 1 | Stop auto-repeat; idle with chip select high |
| one_line_i | input | 1 | 1 = both results on line A in sequence |
| diff_mode_i | input | 1 | Value driven onto the mode pin |
| range_twos_i | input | 1 | Converter output coding, 1 = two's complement |
| want_twos_i | input | 1 | Wanted result coding, 1 = two's complement |
| seq_en_i | input | 1 | Use the address list instead of the fixed address |
| fixed_addr_i | input | 3 | Fixed channel address |
| seq_list_i | input | 12 | Four 3-bit addresses, entry i at [3i+2:3i] |
| seq_last_i | input | 2 | Index of the last list entry used |
| quiet_i | input | 8 | Minimum idle cycles minus one between frames |
| sdata_a_i | input | 1 | Serial data line A |
| sdata_b_i | input | 1 | Serial data line B |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| addr_o | output | 3 | Channel address pins |
| diff_o | output | 1 | Differential/single-ended mode pin |
| res_a_o | output | 12 | Result of converter A |
| res_b_o | output | 12 | Result of converter B |
| res_addr_o | output | 3 | Address used for the returned results |
| res_valid_o | output | 1 | One-cycle strobe for new results |

## Verification
The hardest situations to reach from the ports are the ones that depend on timing between frames. One is a start pulse that lands in the middle of a running frame. Another is sleep raised while an auto-repeating stream is in its quiet gap. The bench reaches the first by watching chip select and pulsing start about twenty cycles after it falls. It reaches the second by raising sleep on the same cycle as a valid strobe, during a back-to-back run with a nonzero quiet count. It then counts the frames that follow, which shows at the ports whether the remembered request or the stop took effect. A converter stand-in drives trailing bits of ones and, in one-line mode, an all-ones line B, so that any misplaced sampling window shows up in the data.

// File: rtl/dar_pkg.sv
package dar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_TAIL = 2'd2
  } dar_state_e;

  // Frame mode, captured at the falling edge of chip select
  typedef struct packed {
    logic one_line;
    logic src_twos;
    logic dst_twos;
  } dar_mode_t;

  // MSB flips when the converter coding and the wanted coding differ
  function automatic logic coding_flip(input dar_mode_t m);
    return m.src_twos ^ m.dst_twos;
  endfunction

endpackage

// File: rtl/dar_clkgen.sv
module dar_clkgen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_evt_o
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick       = (div_q == DW'(HALF_CYC - 1));
  // named event: at this edge sclk goes high and data is sampled
  assign rise_evt_o = run_i & tick & ~sclk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_o <= 1'b1;
    end else if (!run_i) begin
      div_q  <= '0;
      sclk_o <= 1'b1;
    end else if (tick) begin
      div_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // R2: a rise event is followed by a high serial clock
  p_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt_o |=> sclk_o);

endmodule

// File: rtl/dar_deser.sv
module dar_deser #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16,
  parameter int LEAD_W  = 2,
  parameter int TRAIL_W = 2,
  parameter int N_WORDS = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_i,
  input  logic                      din_i,
  output logic [N_WORDS*DATA_W-1:0] words_o
);
  // the leading bits of the earliest word never need storage
  localparam int SR_W = N_WORDS * FRAME_W - LEAD_W;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[SR_W-2:0], din_i};
  end

  // word k in arrival order; later words sit nearer the LSB
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    assign words_o[k*DATA_W +: DATA_W] =
      sr_q[(N_WORDS-1-k)*FRAME_W + TRAIL_W +: DATA_W];
  end

endmodule

// File: rtl/dar_seq.sv
module dar_seq #(
  parameter int ADDR_W    = 3,
  parameter int SEQ_DEPTH = 4,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv_i,
  input  logic                        hold_i,
  input  logic                        seq_en_i,
  input  logic [IDX_W-1:0]            last_i,
  input  logic [SEQ_DEPTH*ADDR_W-1:0] list_i,
  input  logic [ADDR_W-1:0]           fixed_addr_i,
  input  logic                        diff_mode_i,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        diff_o
);
  logic [IDX_W-1:0] idx_q, idx_nx;

  function automatic logic [ADDR_W-1:0] pick(input logic [SEQ_DEPTH*ADDR_W-1:0] lst,
                                             input logic [IDX_W-1:0] i);
    return lst[i*ADDR_W +: ADDR_W];
  endfunction

  always_comb begin
    idx_nx = idx_q;
    if (adv_i && seq_en_i) idx_nx = (idx_q >= last_i) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_o <= '0;
      diff_o <= 1'b0;
    end else begin
      idx_q <= idx_nx;
      if (!hold_i) begin
        addr_o <= seq_en_i ? pick(list_i, idx_nx) : fixed_addr_i;
        diff_o <= diff_mode_i;
      end
    end
  end

  // R8: the index wraps to zero after the last entry
  p_idx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && seq_en_i && idx_q >= last_i) |=> (idx_q == '0));

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dar_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 2,
  parameter int TRAIL_W   = 2,
  parameter int HALF_CYC  = 2,
  parameter int ADDR_W    = 3,
  parameter int SEQ_DEPTH = 4,
  parameter int QUIET_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        sleep_i,
  input  logic                        one_line_i,
  input  logic                        diff_mode_i,
  input  logic                        range_twos_i,
  input  logic                        want_twos_i,
  input  logic                        seq_en_i,
  input  logic [ADDR_W-1:0]           fixed_addr_i,
  input  logic [SEQ_DEPTH*ADDR_W-1:0] seq_list_i,
  input  logic [$clog2(SEQ_DEPTH)-1:0] seq_last_i,
  input  logic [QUIET_W-1:0]          quiet_i,
  input  logic                        sdata_a_i,
  input  logic                        sdata_b_i,
  output logic                        cs_n_o,
  output logic                        sclk_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        diff_o,
  output logic [DATA_W-1:0]           res_a_o,
  output logic [DATA_W-1:0]           res_b_o,
  output logic [ADDR_W-1:0]           res_addr_o,
  output logic                        res_valid_o
);
  localparam int FRAME_W = LEAD_W + DATA_W + TRAIL_W;
  localparam int SR_BITS = 2 * FRAME_W;
  localparam int CNT_W   = $clog2(SR_BITS + 1);
  localparam int HCNT_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int IDX_W   = $clog2(SEQ_DEPTH);

  dar_state_e          state_q, state_nx;
  dar_mode_t           mode_q;
  logic [CNT_W-1:0]    bit_cnt_q, last_bit;
  logic [HCNT_W-1:0]   tail_q;
  logic [QUIET_W-1:0]  quiet_q;
  logic                pend_q, auto_q, req;
  logic                launch, frame_done, rise_evt, run, hold;
  logic [2*DATA_W-1:0] lane_a_w;
  logic [DATA_W-1:0]   lane_b_w;

  function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] raw,
                                               input dar_mode_t m);
    logic [DATA_W-1:0] r;
    r = raw;
    r[DATA_W-1] = raw[DATA_W-1] ^ coding_flip(m);
    return r;
  endfunction

  assign req      = start_i | pend_q | (auto_q & ~sleep_i);
  assign run      = (state_q == ST_CONV);
  assign hold     = (state_nx != ST_IDLE);
  assign last_bit = mode_q.one_line ? CNT_W'(SR_BITS - 1) : CNT_W'(FRAME_W - 1);

  always_comb begin
    state_nx   = state_q;
    launch     = 1'b0;
    frame_done = 1'b0;
    case (state_q)
      ST_IDLE: if (quiet_q == '0 && req) begin
        launch   = 1'b1;
        state_nx = ST_CONV;
      end
      ST_CONV: if (rise_evt && bit_cnt_q == last_bit) state_nx = ST_TAIL;
      ST_TAIL: if (tail_q == HCNT_W'(HALF_CYC - 1)) begin
        frame_done = 1'b1;
        state_nx   = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_n_o    <= 1'b1;
      mode_q    <= '0;
      bit_cnt_q <= '0;
      tail_q    <= '0;
      quiet_q   <= '0;
      pend_q    <= 1'b0;
      auto_q    <= 1'b0;
    end else begin
      state_q <= state_nx;
      cs_n_o  <= ~hold;
      pend_q  <= (pend_q | start_i) & ~launch;
      if (sleep_i) auto_q <= 1'b0;
      else if (launch) auto_q <= 1'b1;
      if (launch) begin
        mode_q    <= '{one_line: one_line_i, src_twos: range_twos_i, dst_twos: want_twos_i};
        bit_cnt_q <= '0;
      end else if (rise_evt) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      tail_q <= (state_q == ST_TAIL) ? tail_q + 1'b1 : '0;
      if (frame_done) quiet_q <= quiet_i;
      else if (state_q == ST_IDLE && quiet_q != '0) quiet_q <= quiet_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_a_o     <= '0;
      res_b_o     <= '0;
      res_addr_o  <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= frame_done;
      if (launch) res_addr_o <= addr_o;
      if (frame_done) begin
        res_a_o <= recode(mode_q.one_line ? lane_a_w[0 +: DATA_W] : lane_a_w[DATA_W +: DATA_W], mode_q);
        res_b_o <= recode(mode_q.one_line ? lane_a_w[DATA_W +: DATA_W] : lane_b_w, mode_q);
      end
    end
  end

  dar_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sclk_o(sclk_o), .rise_evt_o(rise_evt)
  );

  dar_deser #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W),
              .N_WORDS(2)) u_lane_a (
    .clk(clk), .rst_n(rst_n), .shift_i(rise_evt), .din_i(sdata_a_i), .words_o(lane_a_w)
  );

  dar_deser #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W),
              .N_WORDS(1)) u_lane_b (
    .clk(clk), .rst_n(rst_n), .shift_i(rise_evt), .din_i(sdata_b_i), .words_o(lane_b_w)
  );

  dar_seq #(.ADDR_W(ADDR_W), .SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv_i(frame_done), .hold_i(hold), .seq_en_i(seq_en_i),
    .last_i(seq_last_i), .list_i(seq_list_i), .fixed_addr_i(fixed_addr_i),
    .diff_mode_i(diff_mode_i), .addr_o(addr_o), .diff_o(diff_o)
  );

  // ---- checker state, independent of the frame counters ----
  logic             sclk_prev;
  logic [CNT_W-1:0] rise_chk;
  logic [QUIET_W:0] gap_chk;
  logic [QUIET_W-1:0] quiet_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      rise_chk  <= '0;
      gap_chk   <= '0;
      quiet_lat <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (launch) rise_chk <= '0;
      else if (sclk_o && !sclk_prev && !cs_n_o) rise_chk <= rise_chk + 1'b1;
      if (!cs_n_o) gap_chk <= '0;
      else if (gap_chk != '1) gap_chk <= gap_chk + 1'b1;
      if (frame_done) quiet_lat <= quiet_i;
    end
  end

  // R2: serial clock idles high outside a frame
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R2: the number of rising edges matches the frame length
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (rise_chk == (mode_q.one_line ? CNT_W'(SR_BITS) : CNT_W'(FRAME_W))));

  // R5: valid is a single-cycle pulse at chip select rise
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (cs_n_o && !$past(cs_n_o)) ##1 !res_valid_o);

  // R7 / R9: address and mode pins hold during a frame
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$past(cs_n_o)) |-> ($stable(addr_o) && $stable(diff_o)));

  // R10: the quiet gap is honoured
  p_quiet_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (gap_chk >= ({1'b0, quiet_lat} + 1'b1)));

  // R11: sleeping with no request keeps chip select high
  p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sleep_i && !start_i && !pend_q) |=> cs_n_o);

endmodule

// File: tb/tb_dual_adc_reader.sv
module tb_dual_adc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, sleep = 1, one_line = 0, diff_mode = 0, range_twos = 0, want_twos = 0, seq_en = 0;
  logic [2:0] fixed_addr = 3'd0;
  logic [11:0] seq_list = '0;
  logic [1:0] seq_last = 2'd0;
  logic [7:0] quiet = 8'd2;
  logic sda = 1'b0, sdb = 1'b0;
  logic cs_n, sclk, diff_o, res_valid;
  logic [2:0] addr_o, res_addr;
  logic [11:0] res_a, res_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_reader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sleep_i(sleep), .one_line_i(one_line),
    .diff_mode_i(diff_mode), .range_twos_i(range_twos), .want_twos_i(want_twos),
    .seq_en_i(seq_en), .fixed_addr_i(fixed_addr), .seq_list_i(seq_list),
    .seq_last_i(seq_last), .quiet_i(quiet), .sdata_a_i(sda), .sdata_b_i(sdb),
    .cs_n_o(cs_n), .sclk_o(sclk), .addr_o(addr_o), .diff_o(diff_o),
    .res_a_o(res_a), .res_b_o(res_b), .res_addr_o(res_addr), .res_valid_o(res_valid)
  );

  int n_checks = 0, n_err = 0, n_frames = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] to_coding(input logic [11:0] raw, input logic src, input logic dst);
    return (src != dst) ? 12'(raw + 12'd2048) : raw;
  endfunction

  typedef struct { logic [2:0] addr; logic [11:0] a; logic [11:0] b; string tag; } exp_t;
  exp_t sb[$];

  // ---- converter stand-in and scoreboard driver ----
  logic [2:0] exp_addr = 3'd0;
  int fc = 0, bit_k = 0, exp_bits = 16;
  logic [31:0] sh_a;
  logic [15:0] sh_b;

  always @(negedge cs_n) begin
    logic [11:0] a, b;
    exp_t e;
    if (rst_n) begin
      a = 12'((fc * 613 + 291) & 12'hfff);
      b = 12'((fc * 1597 + 3000) & 12'hfff);
      if (fc == 0) begin a = 12'hfff; b = 12'h000; end
      if (fc == 1) begin a = 12'h800; b = 12'h7ff; end
      fc++;
      if (one_line) begin
        sh_a = {2'b00, a, 2'b11, 2'b00, b, 2'b11};
        sh_b = 16'hffff;
        exp_bits = 32;
      end else begin
        sh_a = {2'b00, a, 2'b11, 16'hffff};
        sh_b = {2'b00, b, 2'b11};
        exp_bits = 16;
      end
      bit_k = 0;
      chk(addr_o == exp_addr, seq_en ? "R8" : "R7", "address at cs fall", addr_o, exp_addr);
      chk(diff_o == diff_mode, "R9", "mode pin at cs fall", diff_o, diff_mode);
      e.addr = exp_addr;
      e.a = to_coding(a, range_twos, want_twos);
      e.b = to_coding(b, range_twos, want_twos);
      e.tag = one_line ? "R4" : ((range_twos != want_twos) ? "R6" : "R3");
      sb.push_back(e);
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      sda <= sh_a[31 - bit_k];
      sdb <= (bit_k < 16) ? sh_b[15 - bit_k] : 1'b1;
      bit_k++;
    end
  end

  // ---- monitor: results and frame timing ----
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int t = 0, rises = 0, last_rise_t = 0, gap = 0, exp_gap = 0;
  bit first_fall_seen = 0, gap_en = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        exp_t e;
        chk(cs_n && !prev_cs, "R5", "valid at cs rise", cs_n, 1);
        if (sb.size() == 0) chk(0, "R5", "result without frame", 0, 1);
        else begin
          e = sb.pop_front();
          chk(res_a == e.a, e.tag, "result A", res_a, e.a);
          chk(res_b == e.b, e.tag, "result B", res_b, e.b);
          chk(res_addr == e.addr, "R7", "address tag", res_addr, e.addr);
        end
        n_frames++;
      end
      if (prev_res_valid) chk(!res_valid, "R5", "valid width", res_valid, 0);
      if (!cs_n && prev_cs) begin
        t = 0; rises = 0; first_fall_seen = 0;
        if (gap_en) chk(gap == exp_gap, "R10", "gap length", gap, exp_gap);
      end else t++;
      if (cs_n) gap = prev_cs ? gap + 1 : 1;
      if (!cs_n && !sclk && prev_sclk && !first_fall_seen) begin
        first_fall_seen = 1;
        chk(t == HALF, "R2", "first sclk fall delay", t, HALF);
      end
      if (!cs_n && sclk && !prev_sclk) begin rises++; last_rise_t = t; end
      if (cs_n && !prev_cs) begin
        chk(rises == exp_bits, "R2", "sclk rises per frame", rises, exp_bits);
        chk(t - last_rise_t == HALF, "R2", "cs rise delay", t - last_rise_t, HALF);
      end
      if (cs_n) chk(sclk, "R2", "sclk idle high", sclk, 1);
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
    prev_res_valid = res_valid;
  end
  logic prev_res_valid = 1'b0;

  task automatic wait_frames(input int n);
    int k = 0;
    while (n_frames < n && k < 6000) begin @(negedge clk); k++; end
    chk(n_frames >= n, "R2", "frame completed", n_frames, n);
  endtask

  task automatic do_frame(input logic [2:0] ea);
    int f0 = n_frames;
    exp_addr = ea;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    wait_frames(f0 + 1);
    repeat (4) @(negedge clk);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 1, "R1", "pins in reset", {cs_n, sclk}, 3);
    chk(res_valid == 0 && res_a == 0 && res_b == 0, "R1", "results in reset", res_a + res_b + res_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && res_valid == 0, "R1", "idle after reset", cs_n, 1);

    // two-line, fixed address, same coding
    fixed_addr = 3'd3; repeat (2) @(negedge clk);
    do_frame(3'd3);
    do_frame(3'd3);
    fixed_addr = 3'd5; diff_mode = 1; repeat (2) @(negedge clk);
    do_frame(3'd5);

    // coding conversion both ways
    range_twos = 1; want_twos = 0; do_frame(3'd5);
    range_twos = 0; want_twos = 1; do_frame(3'd5);
    range_twos = 1; want_twos = 1; do_frame(3'd5);
    range_twos = 0; want_twos = 0;

    // one-line mode
    one_line = 1; diff_mode = 0; fixed_addr = 3'd6; repeat (2) @(negedge clk);
    do_frame(3'd6);
    do_frame(3'd6);
    one_line = 0;

    // sequencer: entries 1,4,6,2
    seq_list = {3'd2, 3'd6, 3'd4, 3'd1}; seq_last = 2'd3; seq_en = 1;
    repeat (2) @(negedge clk);
    do_frame(3'd1); do_frame(3'd4); do_frame(3'd6); do_frame(3'd2); do_frame(3'd1);
    seq_last = 2'd1; repeat (2) @(negedge clk);
    do_frame(3'd4); do_frame(3'd1); do_frame(3'd4);
    seq_en = 0; fixed_addr = 3'd2; repeat (2) @(negedge clk);

    // back-to-back with sleep low, then sleep
    quiet = 8'd5; exp_gap = 6; sleep = 0; exp_addr = 3'd2;
    f0 = n_frames;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wait_frames(f0 + 1);
    gap_en = 1;
    wait_frames(f0 + 4);
    sleep = 1;
    gap_en = 0;
    chk(n_frames == f0 + 4, "R11", "frames before sleep", n_frames, f0 + 4);
    repeat (300) @(negedge clk);
    chk(n_frames == f0 + 4, "R11", "no frame while asleep", n_frames, f0 + 4);
    chk(cs_n == 1, "R11", "cs high while asleep", cs_n, 1);

    // start during a running frame
    quiet = 8'd3;
    f0 = n_frames;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (cs_n) @(negedge clk);
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_frames(f0 + 2);
    repeat (300) @(negedge clk);
    chk(n_frames == f0 + 2, "R12", "remembered start gives one frame", n_frames, f0 + 2);
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule